// File: doc/BRIEF.md
# Serial LED Sink Driver Core

This block is the digital heart of a sixteen-channel constant-current LED sink driver. A serial bit stream is clocked into a shift chain. The chain's last stage is echoed on a serial output, so several devices can be cascaded. A strobe input copies the chain into a holding register. The holding register drives the per-channel enable outputs, gated by an active-low enable pin. The analog current sinks, the fault comparators and the thermal protection live outside the block. The comparator verdicts arrive as a vector with one bit per channel.

The strobe and enable pins also carry a second role. A five-clock pattern on the two pins switches the core into a fault-readback mode, and a second pattern switches it back. In fault-readback mode, a pulse on the enable pin lasting two or more clocks samples the per-channel verdicts. When the enable pin returns high, the verdicts are loaded into the shift chain. They then leave on the serial output with the highest channel first. The serial data format is identical in both modes.

Top module: `led_sink_core`

## Requirements
- R1: On every rising clock edge, the chain shifts toward the top. `ser_in` enters bit 0 and `ser_out` shows bit CH-1. A word shifted most-significant bit first therefore sits in the chain after CH edges, and its bit CH-1-j appears on `ser_out` j edges after that.
- R2: At an edge where `strobe` is high, the holding register takes the chain contents as they stand after that edge's shift. At an edge where `strobe` is low, it keeps its value.
- R3: When `oe_n` is high, every bit of `chan_on` is 0. When `oe_n` is low, `chan_on` equals the holding register, where 1 means the channel is sinking.
- R4: In normal mode, the pairs sampled over five consecutive edges are read as {`oe_n`,`strobe`}, oldest first. If they are 10, 00, 10, 11, 10, the core switches to fault-readback mode at the fifth edge.
- R5: In fault-readback mode, the five-edge pattern 10, 00, 10, 10, 10 (same pair encoding) returns the core to normal mode at the fifth edge.
- R6: After a mode-entry pattern, `ser_in` is shifted in from the very next edge onward, with no bit lost or inserted.
- R7: A mode-entry pattern given while already in fault-readback mode is ignored. A mode-return pattern given while already in normal mode is ignored.
- R8: In fault-readback mode, `status_ok` is sampled at each edge where `oe_n` is low. At the first edge where `oe_n` is high again, the chain is loaded with the last sample. `ser_out` then shows channel CH-1 and, on following edges, CH-2 down to 0. A status bit of 1 means the channel is healthy. A rising `oe_n` in normal mode loads nothing.
- R9: A synchronous active-low reset clears the chain and the holding register and selects normal mode.
- R10: After a mode switch, the pattern history is cleared, so the next pattern needs five fresh edges. A low `oe_n` lasting two or more edges never forms part of a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into chain bit 0 |
| strobe | input | 1 | Holding-register load enable; also a pattern pin |
| oe_n | input | 1 | Active-low channel enable; also a pattern pin |
| status_ok | input | CH | Per-channel fault verdict, 1 = healthy |
| ser_out | output | 1 | Top bit of the chain |
| chan_on | output | CH | Per-channel sink enable, 1 = on |

## Verification
The mode flag is internal, so an error in it shows up only indirectly. It shows at the first enable pulse of two or more clocks that ends afterwards: `ser_out` then shows either a loaded status bit or the shifted data, at that same edge. A chain that drops or duplicates a bit around a pattern is seen at `chan_on` as soon as the next strobe is followed by a low enable. A history that is not cleared lets a four-clock tail flip the mode back early, and the next probe reveals this. A holding register that leaks shows at `chan_on` within one clock.

// File: rtl/led_core_pkg.sv
// Shared constants for the LED sink driver core.
// A pattern window holds KEY_LEN pairs {oe_n, strobe}, oldest pair in the
// most significant position.
package led_core_pkg;
    localparam int KEY_LEN = 5;
    localparam int PAIR_W  = 2;
    localparam int WIN_W   = KEY_LEN * PAIR_W;
    localparam int HIST_W  = (KEY_LEN - 1) * PAIR_W;

    // Enter fault-readback: 10 00 10 11 10 (oldest first)
    localparam logic [WIN_W-1:0] KEY_ENTER = 10'b10_00_10_11_10;
    // Return to normal:     10 00 10 10 10 (oldest first)
    localparam logic [WIN_W-1:0] KEY_LEAVE = 10'b10_00_10_10_10;
endpackage

// File: rtl/ser_chain.sv
// Serial-in, parallel-out shift chain with a parallel load.
// Assumes load_en and shift never coincide meaningfully: load wins.
// next_q exposes the value the chain takes at the coming edge.
module ser_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_in,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic [W-1:0] next_q,
    output logic         tail
);
    // Per-stage next value: parallel load or move up one stage.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign next_q[i] = load_en ? load_val[i] : shift_in;
        end else begin : g_body
            assign next_q[i] = load_en ? load_val[i] : q[i-1];
        end
    end

    // Chain register update.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= next_q;
    end

    assign tail = q[W-1];
endmodule

// File: rtl/hold_latch.sv
// Edge-sampled holding register standing in for a transparent latch.
// Captures d at each edge where capture is high, otherwise holds.
module hold_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture-or-hold register.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/key_watch.sv
// Pattern recogniser for the dual-role pins. Keeps the last KEY_LEN-1
// {oe_n, strobe} pairs and compares them plus the current pair with the
// entry or return pattern, depending on the current mode. On a match the
// mode flips and the history is cleared, so every pattern needs fresh edges.
module key_watch
    import led_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic strobe,
    output logic detect
);
    logic [HIST_W-1:0] hist_q;
    logic [WIN_W-1:0]  window;
    logic              hit_enter;
    logic              hit_leave;

    // Window of pairs as of this edge.
    assign window    = {hist_q, oe_n, strobe};
    assign hit_enter = !detect && (window == KEY_ENTER);
    assign hit_leave =  detect && (window == KEY_LEAVE);

    // History shift and mode flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            detect <= 1'b0;
        end else if (hit_enter || hit_leave) begin
            hist_q <= '0;
            detect <= !detect;
        end else begin
            hist_q <= window[HIST_W-1:0];
        end
    end
endmodule

// File: rtl/fault_grab.sv
// Samples per-channel verdicts while the enable pin is low in readback
// mode and asks the chain to load them at the first edge it is high again.
module fault_grab #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         detect,
    input  logic         oe_n,
    input  logic [W-1:0] status_ok,
    output logic         load_en,
    output logic [W-1:0] snap_q
);
    logic oe_prev_q;

    // Track the enable pin and capture verdicts during a low enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_prev_q <= 1'b1;
            snap_q    <= '0;
        end else begin
            oe_prev_q <= oe_n;
            if (detect && !oe_n) snap_q <= status_ok;
        end
    end

    // Load request on the return of the enable pin to high.
    assign load_en = detect && oe_n && !oe_prev_q;
endmodule

// File: rtl/led_sink_core.sv
// Digital core of a serial LED sink driver: shift chain, holding register,
// output gating, mode-pattern recogniser and fault readback path.
// Assumes all pins are synchronous to clk.
module led_sink_core #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          strobe,
    input  logic          oe_n,
    input  logic [CH-1:0] status_ok,
    output logic          ser_out,
    output logic [CH-1:0] chan_on
);
    logic [CH-1:0] sr_q;
    logic [CH-1:0] sr_next;
    logic [CH-1:0] lat_q;
    logic [CH-1:0] snap_q;
    logic          load_en;
    logic          detect;

    key_watch u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .strobe (strobe),
        .detect (detect)
    );

    fault_grab #(.W(CH)) u_grab (
        .clk       (clk),
        .rst_n     (rst_n),
        .detect    (detect),
        .oe_n      (oe_n),
        .status_ok (status_ok),
        .load_en   (load_en),
        .snap_q    (snap_q)
    );

    ser_chain #(.W(CH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_in (ser_in),
        .load_en  (load_en),
        .load_val (snap_q),
        .q        (sr_q),
        .next_q   (sr_next),
        .tail     (ser_out)
    );

    hold_latch #(.W(CH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (strobe),
        .d       (sr_next),
        .q       (lat_q)
    );

    // Output gating by the active-low enable.
    always_comb begin
        chan_on = oe_n ? '0 : lat_q;
    end
endmodule

// File: rtl/led_sink_core_chk.sv
// Property checker for led_sink_core, attached through bind.
module led_sink_core_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         oe_n,
    input logic         strobe,
    input logic         ser_in,
    input logic [W-1:0] chan_on,
    input logic         detect,
    input logic         load_en,
    input logic [W-1:0] lat_q,
    input logic [W-1:0] sr_q,
    input logic [W-1:0] snap_q
);
    assert_dark_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (chan_on == '0));

    assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe) |-> $stable(lat_q));

    assert_chain_shifts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_en) |-> (sr_q == {$past(sr_q[W-2:0]), $past(ser_in)}));

    assert_load_takes_snapshot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_en) |-> (sr_q == $past(snap_q)));

    assert_switch_on_idle_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (detect != $past(detect)) |-> ($past(oe_n) && !$past(strobe)));

    assert_reset_clears_R9: assert property (@(posedge clk)
        $past(!rst_n) |-> (lat_q == '0 && sr_q == '0 && !detect));
endmodule

bind led_sink_core led_sink_core_chk #(.W(CH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_n    (oe_n),
    .strobe  (strobe),
    .ser_in  (ser_in),
    .chan_on (chan_on),
    .detect  (detect),
    .load_en (load_en),
    .lat_q   (lat_q),
    .sr_q    (sr_q),
    .snap_q  (snap_q)
);

// File: tb/led_sink_core_tb_top.sv
module led_sink_core_tb_top;
    localparam int CLK_P = 10;
    localparam int CH    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_in = 1'b0;
    logic          strobe = 1'b0;
    logic          oe_n = 1'b1;
    logic [CH-1:0] status_ok = '0;
    logic          ser_out;
    logic [CH-1:0] chan_on;

    always #(CLK_P/2) clk = ~clk;

    led_sink_core #(.CH(CH)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .strobe    (strobe),
        .oe_n      (oe_n),
        .status_ok (status_ok),
        .ser_out   (ser_out),
        .chan_on   (chan_on)
    );

    typedef struct {
        int unsigned   at;
        bit            is_chan;
        logic [CH-1:0] val;
        string         req;
    } exp_t;

    exp_t        sb_q[$];
    int unsigned cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;

    // Driver: set pins away from the edge; they are sampled at edge cyc+1.
    task automatic drive(input logic o, input logic l, input logic d);
        @(negedge clk);
        oe_n = o; strobe = l; ser_in = d;
    endtask

    task automatic want_ser(input logic b, input string r);
        exp_t e;
        e.at = cyc + 1; e.is_chan = 1'b0; e.val = '0; e.val[0] = b; e.req = r;
        sb_q.push_back(e);
    endtask

    task automatic want_chan(input logic [CH-1:0] v, input string r);
        exp_t e;
        e.at = cyc + 1; e.is_chan = 1'b1; e.val = v; e.req = r;
        sb_q.push_back(e);
    endtask

    // Shift a word most-significant bit first, strobe on the last bit.
    task automatic load_word(input logic [CH-1:0] w);
        for (int i = CH - 1; i >= 0; i--) drive(1'b1, i == 0, w[i]);
    endtask

    task automatic key_enter();
        drive(1'b1, 1'b0, 1'b0); drive(1'b0, 1'b0, 1'b0); drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0); drive(1'b1, 1'b0, 1'b0);
    endtask

    task automatic key_leave();
        drive(1'b1, 1'b0, 1'b0); drive(1'b0, 1'b0, 1'b0); drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0); drive(1'b1, 1'b0, 1'b0);
    endtask

    // Mode probe: zero-fill the chain, pulse enable low for two clocks with
    // all verdicts healthy; ser_out is 1 only if the chain was reloaded.
    task automatic probe(input logic in_detect, input string r);
        status_ok = '1;
        for (int i = 0; i < CH; i++) drive(1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        want_ser(in_detect, r);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pop and compare expectations a quarter period after each edge.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #(CLK_P/4);
            while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
                exp_t          e;
                logic [CH-1:0] act;
                e = sb_q.pop_front();
                act = e.is_chan ? chan_on : {{(CH-1){1'b0}}, ser_out};
                n_cmp++;
                if (act !== e.val || e.at != cyc) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d %s actual=%h expected=%h",
                             e.req, cyc, e.is_chan ? "chan_on" : "ser_out", act, e.val);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_P * 20000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [CH-1:0] w1, w2, v, f;
        w1 = 16'hC3A5; w2 = 16'h5E17; v = 16'hA5C3; f = 16'hB2D4;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: cleared state right after reset
        drive(1'b0, 1'b0, 1'b0);
        want_chan('0, "R9"); want_ser(1'b0, "R9");

        // R1/R2: load first word with enable high -> dark (R3)
        load_word(w1);
        want_chan('0, "R3");

        // Shift second word with enable low: hold first word, old bits emerge
        for (int j = 1; j <= CH; j++) begin
            drive(1'b0, j == CH, w2[CH-j]);
            if (j < CH) begin
                want_chan(w1, "R2");
                want_ser(w1[CH-1-j], "R1");
            end else begin
                want_chan(w2, "R2");
                want_ser(w2[CH-1], "R1");
            end
        end

        // R3: enable gating
        drive(1'b1, 1'b0, 1'b0); want_chan('0, "R3");
        drive(1'b0, 1'b0, 1'b0); want_chan(w2, "R3");

        // R4 and R6: enter readback, first data bit at the next edge
        key_enter();
        status_ok = f;
        load_word(v);
        drive(1'b0, 1'b0, 1'b0); want_chan(v, "R4 R6");
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0); want_ser(f[CH-1], "R8");
        for (int i = CH - 2; i >= 0; i--) begin
            drive(1'b1, 1'b0, 1'b0); want_ser(f[i], "R8");
        end

        // R7: repeated entry ignored
        key_enter();
        probe(1'b1, "R7");

        // R5: return to normal; R8: no reload in normal mode
        key_leave();
        probe(1'b0, "R5 R8");

        // R7: repeated return ignored
        key_leave();
        probe(1'b0, "R7");

        // R10: a four-clock tail after entry must not return to normal
        key_enter();
        drive(1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0);
        probe(1'b1, "R10");

        key_leave();
        probe(1'b0, "R5");

        repeat (3) @(posedge clk);
        #(CLK_P/2);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
        end
        summary();
        $finish;
    end
endmodule